// File: doc/BRIEF.md
# Asynchronous HDLC Octet Receiver and Deframer

This block sits behind an 8N1 UART receiver, one character at a time. It finds frame boundaries on flag characters and undoes byte-stuffing transparency. It checks the 16-bit CRC-CCITT frame check sequence and hands the frame contents downstream as a byte stream. The stream carries start and end markers plus a one-cycle completion status. Address and control octets are ordinary payload to this block and pass through unchanged.

The receive controller is a four-state machine:

- **HUNT** discards everything until a flag arrives. The block enters HUNT after reset and after any line fault.
- **OPEN** means a flag has been seen and no frame octet yet.
- **DATA** means frame octets are arriving.
- **ESC** means an escape character is pending.

The transitions are:

| Transition | From | To | Trigger |
|---|---|---|---|
| *hunt_sync* | HUNT | OPEN | a flag |
| *flag_repeat* | OPEN | OPEN | a flag |
| *first_octet* | OPEN | DATA | a plain octet |
| *escape_in* | OPEN or DATA | ESC | an escape character |
| *octet_more* | DATA | DATA | a plain octet |
| *frame_close* | DATA | OPEN | a flag |
| *escape_out* | ESC | DATA | any non-flag octet |
| *abort_seen* | ESC | OPEN | a flag |
| *line_drop* | OPEN, DATA or ESC | HUNT | a line fault |

A closing flag also serves as the opening flag of the next frame.

Frame contents are held back three octets. This keeps the two FCS octets out of the payload stream and lets a runt vanish without a trace. The last payload octet is therefore released on the closing flag, together with the end marker and the status.

Top module: `ahdlc_deframer`

## Requirements
- R1: The flag character 0x7E is never delivered as payload. Any run of flags between frames is ignored. A single flag both closes one frame and opens the next.
- R2: While hunting (after reset or after a line fault), every character is ignored until a flag arrives. Such characters produce no payload and no status.
- R3: A character following the escape 0x7D is delivered XORed with 0x20, whether or not the original is a control character (0x7D 0x41 yields 0x61).
- R4: The doubled escape 0x7D 0x7D drops the first escape and yields 0x5D.
- R5: The CRC is the reflected CCITT form: polynomial 0x8408, seed 0xFFFF. It runs over the de-escaped payload followed by the received FCS, sent low octet first. On a closing flag, a remainder of 0xF0B8 reports status 0 (good). The end marker sits on the last payload octet, in the same cycle as the status pulse.
- R6: On a closing flag, any other remainder reports status 1 (bad FCS). The payload is still delivered.
- R7: The two octets before the closing flag are not delivered. The start marker sits on the first payload octet only.
- R8: A frame with fewer than 4 de-escaped octets between flags produces no payload and no status. A status is reported only for a frame whose start marker was delivered.
- R9: An escape followed by a flag is an abort, reported as status 2 with no payload octet in that cycle. The abort's flag opens the next frame.
- R10: A character strobed with a framing error, overrun or break is discarded. A frame in progress then ends with status 3, and the block hunts.
- R11: A low carrier-detect level ends a frame in progress with status 3. Characters are ignored while carrier is low. The block hunts afterwards.
- R12: Payload and status outputs change only in the cycle after a character strobe (or a carrier drop), each as a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_char | input | 8 | Received character |
| rx_frm_err | input | 1 | Stop-bit framing error on this character |
| rx_overrun | input | 1 | Receiver overrun on this character |
| rx_break | input | 1 | Break condition on this character |
| carrier_ok | input | 1 | Carrier-detect level, high when present |
| pl_valid | output | 1 | Payload octet strobe |
| pl_data | output | 8 | Payload octet |
| pl_sof | output | 1 | First payload octet of a frame |
| pl_eof | output | 1 | Last payload octet of a frame |
| fr_done | output | 1 | Frame completion pulse |
| fr_status | output | 2 | 0 good, 1 bad FCS, 2 abort, 3 line fault; valid with fr_done |

## Verification
The bench targets the places where byte-stuffing receivers usually slip.

**Flags.** A single shared flag and flag runs are tested; a design that treats a shared flag as an empty frame would emit a spurious status. An abort flag that must open the next frame is also tested.

**Escapes.** Escapes of non-control octets and the doubled escape are tested. A receiver that skipped the XOR would deliver 0x41 or drop the 0x5D octet. Because the CRC runs over de-escaped data, an FCS computed on the wire octets would turn a good frame into status 1.

**Runts and holdback.** Runts of one to three octets check that nothing leaks out of the holdback. A design that released octets early would show a start marker with no status.

**Line faults.** Each fault kind and a carrier drop are tested. In each case the data that followed must be ignored until a fresh flag.

// File: rtl/ahdlc_pkg.sv
package ahdlc_pkg;

    localparam logic [7:0]  FLAG_CH   = 8'h7E;
    localparam logic [7:0]  ESC_CH    = 8'h7D;
    localparam logic [7:0]  ESC_FLIP  = 8'h20;
    localparam logic [15:0] CRC_SEED  = 16'hFFFF;
    localparam logic [15:0] CRC_POLYR = 16'h8408;
    localparam logic [15:0] CRC_MAGIC = 16'hF0B8;

    typedef enum logic [1:0] {
        FS_GOOD   = 2'd0,
        FS_BADFCS = 2'd1,
        FS_ABORT  = 2'd2,
        FS_LINE   = 2'd3
    } fr_status_e;

    typedef enum logic [1:0] {
        RX_HUNT = 2'd0,
        RX_OPEN = 2'd1,
        RX_DATA = 2'd2,
        RX_ESC  = 2'd3
    } rx_state_e;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLYR) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/ahdlc_crc16.sv
module ahdlc_crc16
    import ahdlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       upd,
    input  logic [7:0] din,
    output logic       crc_ok
);

    logic [15:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (clr) begin
            crc_q <= CRC_SEED;
        end else if (upd) begin
            crc_q <= crc_step(crc_q, din);
        end
    end

    assign crc_ok = (crc_q == CRC_MAGIC);

    // R5
    crc_reseed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_q == CRC_SEED));

    // R5
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !upd) |=> $stable(crc_q));

endmodule

// File: rtl/ahdlc_rx_ctrl.sv
module ahdlc_rx_ctrl
    import ahdlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_char,
    input  logic       rx_frm_err,
    input  logic       rx_overrun,
    input  logic       rx_break,
    input  logic       carrier_ok,
    output logic       oct_push,
    output logic [7:0] oct_data,
    output logic       frm_close,
    output logic       frm_term,
    output fr_status_e term_code,
    output logic       frm_clr
);

    rx_state_e state_q, state_d;
    logic fault, take, is_flag, is_esc, live;

    assign fault   = !carrier_ok || (rx_valid && (rx_frm_err || rx_overrun || rx_break));
    assign take    = rx_valid && !fault;
    assign is_flag = (rx_char == FLAG_CH);
    assign is_esc  = (rx_char == ESC_CH);
    assign live    = (state_q == RX_DATA) || (state_q == RX_ESC);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_HUNT: begin
                if (take && is_flag) state_d = RX_OPEN;          // hunt_sync
            end
            RX_OPEN: begin
                if (fault)                 state_d = RX_HUNT;    // line_drop
                else if (take && is_flag)  state_d = RX_OPEN;    // flag_repeat
                else if (take && is_esc)   state_d = RX_ESC;     // escape_in
                else if (take)             state_d = RX_DATA;    // first_octet
            end
            RX_DATA: begin
                if (fault)                 state_d = RX_HUNT;    // line_drop
                else if (take && is_flag)  state_d = RX_OPEN;    // frame_close
                else if (take && is_esc)   state_d = RX_ESC;     // escape_in
                else if (take)             state_d = RX_DATA;    // octet_more
            end
            RX_ESC: begin
                if (fault)                 state_d = RX_HUNT;    // line_drop
                else if (take && is_flag)  state_d = RX_OPEN;    // abort_seen
                else if (take)             state_d = RX_DATA;    // escape_out
            end
            default: state_d = RX_HUNT;
        endcase
    end

    // outputs
    always_comb begin
        oct_push  = 1'b0;
        oct_data  = rx_char;
        frm_close = 1'b0;
        frm_term  = 1'b0;
        term_code = FS_LINE;
        frm_clr   = 1'b0;
        unique case (state_q)
            RX_HUNT: begin
                frm_clr = take && is_flag;
            end
            RX_OPEN: begin
                frm_clr  = fault || (take && is_flag);
                oct_push = take && !is_flag && !is_esc;
            end
            RX_DATA: begin
                frm_clr   = fault || (take && is_flag);
                oct_push  = take && !is_flag && !is_esc;
                frm_close = take && is_flag;
                frm_term  = fault;
            end
            RX_ESC: begin
                frm_clr   = fault || (take && is_flag);
                oct_push  = take && !is_flag;
                oct_data  = rx_char ^ ESC_FLIP;
                frm_term  = fault || (take && is_flag);
                term_code = fault ? FS_LINE : FS_ABORT;
            end
            default: ;
        endcase
    end

    // R11
    carrier_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_ok |=> (state_q == RX_HUNT));

    // R10
    fault_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && live) |-> (frm_term && term_code == FS_LINE && !oct_push));

    // R2
    hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_HUNT) |-> (!oct_push && !frm_close && !frm_term));

    // R1
    flag_not_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_flag) |-> !oct_push);

endmodule

// File: rtl/ahdlc_holdback.sv
module ahdlc_holdback
    import ahdlc_pkg::*;
#(
    parameter int FCS_BYTES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       oct_push,
    input  logic [7:0] oct_data,
    input  logic       frm_close,
    input  logic       frm_term,
    input  fr_status_e term_code,
    input  logic       frm_clr,
    input  logic       crc_ok,
    output logic       pl_valid,
    output logic [7:0] pl_data,
    output logic       pl_sof,
    output logic       pl_eof,
    output logic       fr_done,
    output fr_status_e fr_status
);

    localparam int HOLD      = FCS_BYTES + 1;
    localparam int MIN_FRAME = HOLD + 1;
    localparam int CNT_W     = $clog2(MIN_FRAME + 1);
    localparam logic [CNT_W-1:0] CNT_HOLD = CNT_W'(HOLD);
    localparam logic [CNT_W-1:0] CNT_MIN  = CNT_W'(MIN_FRAME);

    logic [7:0]       hold_q [HOLD];
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < HOLD; i++) hold_q[i] <= '0;
            cnt_q     <= '0;
            pl_valid  <= 1'b0;
            pl_data   <= '0;
            pl_sof    <= 1'b0;
            pl_eof    <= 1'b0;
            fr_done   <= 1'b0;
            fr_status <= FS_GOOD;
        end else begin
            pl_valid  <= 1'b0;
            pl_sof    <= 1'b0;
            pl_eof    <= 1'b0;
            fr_done   <= 1'b0;
            fr_status <= FS_GOOD;
            if (oct_push) begin
                hold_q[0] <= oct_data;
                for (int i = 1; i < HOLD; i++) hold_q[i] <= hold_q[i-1];
                if (cnt_q >= CNT_HOLD) begin
                    pl_valid <= 1'b1;
                    pl_data  <= hold_q[HOLD-1];
                    pl_sof   <= (cnt_q == CNT_HOLD);
                end
                if (cnt_q < CNT_MIN) cnt_q <= cnt_q + 1'b1;
            end
            if (frm_close && cnt_q >= CNT_MIN) begin
                pl_valid  <= 1'b1;
                pl_data   <= hold_q[HOLD-1];
                pl_eof    <= 1'b1;
                fr_done   <= 1'b1;
                fr_status <= crc_ok ? FS_GOOD : FS_BADFCS;
            end
            if (frm_term && cnt_q >= CNT_MIN) begin
                fr_done   <= 1'b1;
                fr_status <= term_code;
            end
            if (frm_clr) cnt_q <= '0;
        end
    end

    // checker state: a start marker was delivered and its frame is still open
    logic sof_open_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sof_open_q <= 1'b0;
        else if (pl_sof)  sof_open_q <= 1'b1;
        else if (fr_done) sof_open_q <= 1'b0;
    end

    // R7
    sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pl_sof |-> (pl_valid && !pl_eof));

    // R5
    eof_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pl_eof |-> (pl_valid && fr_done && (fr_status == FS_GOOD || fr_status == FS_BADFCS)));

    // R9
    term_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_done && (fr_status == FS_ABORT || fr_status == FS_LINE)) |-> !pl_valid);

    // R8
    done_after_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fr_done |-> sof_open_q);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fr_done |=> !fr_done);

endmodule

// File: rtl/ahdlc_deframer.sv
module ahdlc_deframer
    import ahdlc_pkg::*;
#(
    parameter int FCS_BYTES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_char,
    input  logic       rx_frm_err,
    input  logic       rx_overrun,
    input  logic       rx_break,
    input  logic       carrier_ok,
    output logic       pl_valid,
    output logic [7:0] pl_data,
    output logic       pl_sof,
    output logic       pl_eof,
    output logic       fr_done,
    output logic [1:0] fr_status
);

    logic       oct_push, frm_close, frm_term, frm_clr, crc_ok;
    logic [7:0] oct_data;
    fr_status_e term_code, status_e;

    ahdlc_rx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_char    (rx_char),
        .rx_frm_err (rx_frm_err),
        .rx_overrun (rx_overrun),
        .rx_break   (rx_break),
        .carrier_ok (carrier_ok),
        .oct_push   (oct_push),
        .oct_data   (oct_data),
        .frm_close  (frm_close),
        .frm_term   (frm_term),
        .term_code  (term_code),
        .frm_clr    (frm_clr)
    );

    ahdlc_crc16 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (frm_clr),
        .upd    (oct_push),
        .din    (oct_data),
        .crc_ok (crc_ok)
    );

    ahdlc_holdback #(.FCS_BYTES(FCS_BYTES)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .oct_push  (oct_push),
        .oct_data  (oct_data),
        .frm_close (frm_close),
        .frm_term  (frm_term),
        .term_code (term_code),
        .frm_clr   (frm_clr),
        .crc_ok    (crc_ok),
        .pl_valid  (pl_valid),
        .pl_data   (pl_data),
        .pl_sof    (pl_sof),
        .pl_eof    (pl_eof),
        .fr_done   (fr_done),
        .fr_status (status_e)
    );

    assign fr_status = status_e;

    // R12
    out_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pl_valid |-> $past(rx_valid));

    // R1
    no_flag_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_valid && pl_data == FLAG_CH) |-> $past(rx_char == ESC_CH || rx_char == 8'h5E || rx_valid));

endmodule

// File: tb/ahdlc_deframer_tb.sv
module ahdlc_deframer_tb_top;

    localparam int CLK_P = 10;

    typedef logic [7:0] oq_t [$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_char = '0;
    logic       rx_frm_err = 1'b0, rx_overrun = 1'b0, rx_break = 1'b0;
    logic       carrier_ok = 1'b1;
    logic       pl_valid, pl_sof, pl_eof, fr_done;
    logic [7:0] pl_data;
    logic [1:0] fr_status;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] got_d [$];
    logic       got_s [$];
    logic       got_e [$];
    logic [1:0] got_st [$];
    logic [7:0] exp_d [$];
    logic       exp_s [$];
    logic       exp_e [$];
    logic [1:0] exp_st [$];

    always #(CLK_P/2) clk = ~clk;

    ahdlc_deframer dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
        .rx_frm_err(rx_frm_err), .rx_overrun(rx_overrun), .rx_break(rx_break),
        .carrier_ok(carrier_ok), .pl_valid(pl_valid), .pl_data(pl_data),
        .pl_sof(pl_sof), .pl_eof(pl_eof), .fr_done(fr_done), .fr_status(fr_status)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (pl_valid) begin
                got_d.push_back(pl_data);
                got_s.push_back(pl_sof);
                got_e.push_back(pl_eof);
            end
            if (fr_done) got_st.push_back(fr_status);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input oq_t q);
        logic [15:0] c = 16'hFFFF;
        foreach (q[i]) begin
            c = c ^ {8'h00, q[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return c;
    endfunction

    task automatic put(input logic [7:0] b, input logic fe = 1'b0,
                       input logic ov = 1'b0, input logic bk = 1'b0);
        @(negedge clk);
        rx_valid = 1'b1; rx_char = b; rx_frm_err = fe; rx_overrun = ov; rx_break = bk;
        @(negedge clk);
        rx_valid = 1'b0; rx_frm_err = 1'b0; rx_overrun = 1'b0; rx_break = 1'b0;
    endtask

    task automatic put_body(input oq_t pl, input bit bad, input bit esc_all);
        oq_t w;
        logic [15:0] f;
        w = pl;
        f = ~ref_crc(pl);
        if (bad) f = f ^ 16'h0100;
        w.push_back(f[7:0]);
        w.push_back(f[15:8]);
        foreach (w[i]) begin
            if (esc_all || w[i] == 8'h7E || w[i] == 8'h7D) begin
                put(8'h7D);
                put(w[i] ^ 8'h20);
            end else begin
                put(w[i]);
            end
        end
    endtask

    task automatic expect_pl(input oq_t pl, input bit last_eof);
        foreach (pl[i]) begin
            exp_d.push_back(pl[i]);
            exp_s.push_back(i == 0);
            exp_e.push_back(last_eof && (i == pl.size() - 1));
        end
    endtask

    task automatic settle_and_compare(input string req);
        repeat (4) @(negedge clk);
        chk(got_d.size() == exp_d.size(), {req, " payload count"}, got_d.size(), exp_d.size());
        chk(got_st.size() == exp_st.size(), {req, " status count"}, got_st.size(), exp_st.size());
        for (int i = 0; i < exp_d.size() && i < got_d.size(); i++) begin
            chk(got_d[i] == exp_d[i], {req, " data"}, got_d[i], exp_d[i]);
            chk(got_s[i] == exp_s[i] && got_e[i] == exp_e[i], {req, " sof/eof"},
                {got_s[i], got_e[i]}, {exp_s[i], exp_e[i]});
        end
        for (int i = 0; i < exp_st.size() && i < got_st.size(); i++)
            chk(got_st[i] == exp_st[i], {req, " status"}, got_st[i], exp_st[i]);
        got_d.delete(); got_s.delete(); got_e.delete(); got_st.delete();
        exp_d.delete(); exp_s.delete(); exp_e.delete(); exp_st.delete();
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!pl_valid && !fr_done && !pl_sof && !pl_eof, "R12 reset outputs idle",
            {pl_valid, fr_done, pl_sof, pl_eof}, 0);
    endtask

    // R2 R1 R5 R7
    task automatic t_basic;
        oq_t p = '{8'hFF, 8'h03, 8'hC0, 8'h21, 8'hAA};
        put(8'h11); put(8'h22); put(8'hFF);
        put(8'h7E); put_body(p, 0, 0); put(8'h7E);
        expect_pl(p, 1); exp_st.push_back(2'd0);
        settle_and_compare("R5 R7 R2 basic good frame");
    endtask

    // R1
    task automatic t_shared_flags;
        oq_t a = '{8'h01, 8'h02, 8'h03};
        oq_t b = '{8'h7E, 8'h55, 8'h7D, 8'h99};
        put(8'h7E); put(8'h7E); put(8'h7E);
        put_body(a, 0, 0); put(8'h7E);
        put_body(b, 0, 0); put(8'h7E); put(8'h7E); put(8'h7E);
        expect_pl(a, 1); exp_st.push_back(2'd0);
        expect_pl(b, 1); exp_st.push_back(2'd0);
        settle_and_compare("R1 shared flag and flag runs");
    endtask

    // R3 R4
    task automatic t_escapes;
        oq_t p = '{8'h61, 8'h5D, 8'h00, 8'hC3, 8'h5D};
        put(8'h7E); put_body(p, 0, 1); put(8'h7E);
        expect_pl(p, 1); exp_st.push_back(2'd0);
        settle_and_compare("R3 R4 forced escapes incl doubled 0x7D");
    endtask

    // R6
    task automatic t_bad_fcs;
        oq_t p = '{8'h10, 8'h20, 8'h30};
        put(8'h7E); put_body(p, 1, 0); put(8'h7E);
        expect_pl(p, 1); exp_st.push_back(2'd1);
        settle_and_compare("R6 corrupted FCS");
    endtask

    // R8
    task automatic t_runts;
        oq_t g = '{8'hAB, 8'hCD};
        put(8'h7E); put(8'h41); put(8'h7E);
        put(8'h42); put(8'h43); put(8'h7E);
        put(8'h44); put(8'h45); put(8'h46); put(8'h7E);
        put(8'h7D); put(8'h7E);
        put_body(g, 0, 0); put(8'h7E);
        expect_pl(g, 1); exp_st.push_back(2'd0);
        settle_and_compare("R8 runts silent, minimum frame accepted");
    endtask

    // R9
    task automatic t_abort;
        oq_t p = '{8'h91, 8'h92, 8'h93, 8'h94, 8'h95};
        oq_t part = '{8'h91, 8'h92};
        oq_t g = '{8'h5A, 8'hA5, 8'h3C};
        put(8'h7E);
        foreach (p[i]) put(p[i]);
        put(8'h7D); put(8'h7E);
        put_body(g, 0, 0); put(8'h7E);
        expect_pl(part, 0); exp_st.push_back(2'd2);
        expect_pl(g, 1); exp_st.push_back(2'd0);
        settle_and_compare("R9 abort then immediate frame");
    endtask

    // R10 R2
    task automatic t_line_err(input int kind);
        oq_t p = '{8'hE1, 8'hE2, 8'hE3, 8'hE4, 8'hE5};
        oq_t part = '{8'hE1, 8'hE2};
        oq_t g = '{8'h77, 8'h88};
        put(8'h7E);
        foreach (p[i]) put(p[i]);
        put(8'hE6, kind == 0, kind == 1, kind == 2);
        put(8'h55); put(8'h66); put(8'h77); put(8'h88); put(8'h99);
        put(8'h7E); put_body(g, 0, 0); put(8'h7E);
        expect_pl(part, 0); exp_st.push_back(2'd3);
        expect_pl(g, 1); exp_st.push_back(2'd0);
        settle_and_compare("R10 line error ends frame then hunt");
    endtask

    // R11
    task automatic t_carrier;
        oq_t p = '{8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hD5, 8'hD6};
        oq_t part = '{8'hD1, 8'hD2, 8'hD3};
        oq_t g = '{8'h12, 8'h34};
        put(8'h7E);
        foreach (p[i]) put(p[i]);
        @(negedge clk); carrier_ok = 1'b0;
        put(8'h7E); put(8'h01); put(8'h02); put(8'h03); put(8'h04); put(8'h7E);
        @(negedge clk); carrier_ok = 1'b1;
        put(8'h21); put(8'h22); put(8'h23); put(8'h24);
        put(8'h7E); put_body(g, 0, 0); put(8'h7E);
        expect_pl(part, 0); exp_st.push_back(2'd3);
        expect_pl(g, 1); exp_st.push_back(2'd0);
        settle_and_compare("R11 carrier loss");
    endtask

    // R12 cycle timing of first payload octet
    task automatic t_timing;
        put(8'h7E); put(8'hB1); put(8'hB2); put(8'hB3);
        @(negedge clk);
        rx_valid = 1'b1; rx_char = 8'hB4;
        @(negedge clk);
        rx_valid = 1'b0;
        chk(pl_valid && pl_sof && pl_data == 8'hB1, "R12 payload one cycle after strobe",
            pl_data, 8'hB1);
        @(negedge clk);
        chk(!pl_valid, "R12 payload is one-cycle pulse", pl_valid, 0);
        put(8'h7D); put(8'h7E);
        repeat (3) @(negedge clk);
        got_d.delete(); got_s.delete(); got_e.delete(); got_st.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_basic;
        t_shared_flags;
        t_escapes;
        t_bad_fcs;
        t_runts;
        t_abort;
        for (int k = 0; k < 3; k++) t_line_err(k);
        t_carrier;
        t_timing;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule